// File: doc/BRIEF.md
# Flash Program/Erase Lock and Status Front End

This block sits between a 32-bit register bus and an on-chip flash program/erase engine. Software reaches eight word-indexed registers: index 0 takes the key words for the main array, index 1 takes the key words for the user data area, index 2 is the status register, index 3 is the control register, index 4 holds the target address, a write to index 5 launches a program of the written halfword, and a write to index 6 launches an erase at the target address. Index 7 and both key ports read zero. Reads are combinational from the registered state. Writes take effect at the clock edge that samples them.

Each area has its own lock. A lock opens only after two key writes in the correct order. A wrong word jams that lock until reset. A launch that passes its lock runs a one-cycle screening step first. Targets inside the protected window, and program targets that do not read back as erased, are refused there with an error flag and a done flag. Any other launch sends a one-cycle start request with address, data and operation type toward the flash. It then waits for the done pulse. Status flags are sticky and are cleared by writing one. One interrupt line combines them through two enables.

The asynchronous active-low reset is released through a two-stage synchronizer, so the block leaves reset on the second rising edge after `rst_n` goes high.

Top module: `flash_ctl_front`

## Requirements
- R1: Reads of index 0 and index 1 always return zero, including right after key words have been written there.
- R2: After reset the control register reads 0x0000_0080: the main lock (bit 7) is set and the user-area open bit (bit 9) is clear. While the lock that governs the target is set, a launch at index 5 or 6 is dropped: busy stays low, no start pulse, no flag changes.
- R3: The main lock opens after index 0 receives 0x4567_0123 and then 0xCDEF_89AB. Any other word at either step jams the lock, and later key writes are ignored until reset. Writing control with bit 7 = 1 re-locks it, and a fresh key pair opens it again.
- R4: Addresses at or above 0xF000 belong to the user area and are governed only by the user lock. Its key pair is written to index 1. Control bit 9 reads 1 while that lock is open. A control write with bit 9 = 0 re-locks the user area, and writing 1 to bit 9 is ignored.
- R5: Status bit 0 (busy, read-only) is high from the edge that accepts a launch until the operation ends. A launch made while busy is dropped.
- R6: Status bit 5 (done) is set when the flash returns its done pulse during a running operation. Writing 1 to bit 5 clears it, and writing 0 leaves it.
- R7: A target in the protected window 0x0100..0x01FF, for program or erase, sets status bit 4 and bit 5. Busy drops on that same edge and no start pulse is issued. Bit 4 is cleared by writing 1.
- R8: A program whose target cell value `fl_cur` is not 0xFFFF sets status bits 2 and 5, with busy low and no start. An erase skips this check. Bit 2 is cleared by writing 1.
- R9: `irq` = (status bit 5 AND control bit 12) OR ((status bit 4 OR status bit 2) AND control bit 10).
- R10: Status bits 31:6, 3 and 1 read zero, and writes to them have no effect on any flag.
- R11: An accepted operation that passes screening produces exactly one `fl_start` cycle. During that cycle `fl_addr`, `fl_wdata` and `fl_erase` carry the launched address, data and operation (1 = erase).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| fl_start | output | 1 | One-cycle request to the flash engine |
| fl_erase | output | 1 | Operation type: 1 = erase, 0 = program |
| fl_addr | output | 16 | Target address of the current operation |
| fl_wdata | output | 16 | Halfword to program |
| fl_cur | input | 16 | Present content of the cell at `fl_addr` |
| fl_done | input | 1 | Completion pulse from the flash engine |
| irq | output | 1 | Combined interrupt |

## Verification
A table of launches varies the operation type, the target address and the present cell value. Each combination lands in exactly one outcome: clean done, protection refusal or not-erased refusal. Addresses 0x00FF, 0x0150, 0x01FF and 0x0200 pin both window edges, and an erase over a non-blank cell shows that erase skips the blank check. Directed sequences then try keys in the right order, the wrong order and after a jam. They launch while locked, while busy and into the user area under each lock. They walk the two interrupt enables against each flag, so that the done term and the error term are told apart.

// File: rtl/flc_pkg.sv
package flc_pkg;

  localparam int BUS_W  = 32;
  localparam int RIDX_W = 3;

  typedef enum logic [RIDX_W-1:0] {
    RI_KEY   = 3'd0,
    RI_UKEY  = 3'd1,
    RI_STS   = 3'd2,
    RI_CTRL  = 3'd3,
    RI_ADDR  = 3'd4,
    RI_PROG  = 3'd5,
    RI_ERASE = 3'd6,
    RI_NONE  = 3'd7
  } reg_idx_e;

  // status bit positions
  localparam int ST_BUSY = 0;
  localparam int ST_PRG  = 2;
  localparam int ST_PROT = 4;
  localparam int ST_DONE = 5;

  // control bit positions
  localparam int CT_LOCK  = 7;
  localparam int CT_UOPEN = 9;
  localparam int CT_ERRIE = 10;
  localparam int CT_DONIE = 12;

  typedef enum logic [1:0] {
    LK_FIRST  = 2'd0,
    LK_SECOND = 2'd1,
    LK_OPEN   = 2'd2,
    LK_JAM    = 2'd3
  } lock_st_e;

  typedef enum logic [1:0] {
    EN_IDLE  = 2'd0,
    EN_CHECK = 2'd1,
    EN_RUN   = 2'd2
  } eng_st_e;

endpackage

// File: rtl/flc_unlock.sv
module flc_unlock
  import flc_pkg::*;
#(
  parameter logic [BUS_W-1:0] KEY_FIRST  = 32'h4567_0123,
  parameter logic [BUS_W-1:0] KEY_SECOND = 32'hCDEF_89AB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [BUS_W-1:0] key_val,
  input  logic             relock,
  output logic             open
);

  lock_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      LK_FIRST:  if (key_wr) st_d = (key_val == KEY_FIRST)  ? LK_SECOND : LK_JAM;
      LK_SECOND: if (key_wr) st_d = (key_val == KEY_SECOND) ? LK_OPEN   : LK_JAM;
      LK_OPEN:   if (relock) st_d = LK_FIRST;
      LK_JAM:    st_d = LK_JAM;
      default:   st_d = LK_JAM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_FIRST;
    else        st_q <= st_d;
  end

  assign open = (st_q == LK_OPEN);

endmodule

// File: rtl/flc_engine.sv
module flc_engine
  import flc_pkg::*;
#(
  parameter int          FADDR_W  = 16,
  parameter int          DATA_W   = 16,
  parameter int unsigned USD_BASE = 32'h0000_F000,
  parameter int unsigned PROT_LO  = 32'h0000_0100,
  parameter int unsigned PROT_HI  = 32'h0000_01FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic               launch_erase,
  input  logic [FADDR_W-1:0] tgt_addr,
  input  logic [DATA_W-1:0]  launch_data,
  input  logic               main_open,
  input  logic               usd_open,
  input  logic [DATA_W-1:0]  fl_cur,
  input  logic               fl_done,
  output logic               busy,
  output logic               running,
  output logic               fl_start,
  output logic               fl_erase,
  output logic [FADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0]  fl_wdata,
  output logic               set_done,
  output logic               set_prot,
  output logic               set_prog
);

  localparam logic [FADDR_W-1:0] USD_A  = FADDR_W'(USD_BASE);
  localparam logic [FADDR_W-1:0] PLO_A  = FADDR_W'(PROT_LO);
  localparam logic [FADDR_W-1:0] PHI_A  = FADDR_W'(PROT_HI);
  localparam logic [DATA_W-1:0]  BLANK  = {DATA_W{1'b1}};

  eng_st_e            st_q, st_d;
  logic               erase_q;
  logic [FADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]  data_q;
  logic               start_q, start_d;
  logic               cap_en;
  logic               tgt_in_usd, allowed, prot_hit, not_blank;

  assign tgt_in_usd = (tgt_addr >= USD_A);
  assign allowed    = tgt_in_usd ? usd_open : main_open;
  assign prot_hit   = (addr_q >= PLO_A) && (addr_q <= PHI_A);
  assign not_blank  = (fl_cur != BLANK);

  always_comb begin
    st_d     = st_q;
    start_d  = 1'b0;
    cap_en   = 1'b0;
    set_done = 1'b0;
    set_prot = 1'b0;
    set_prog = 1'b0;
    case (st_q)
      EN_IDLE: begin
        if (launch && allowed) begin
          cap_en = 1'b1;
          st_d   = EN_CHECK;
        end
      end
      EN_CHECK: begin
        if (prot_hit) begin
          set_prot = 1'b1;
          set_done = 1'b1;
          st_d     = EN_IDLE;
        end else if (!erase_q && not_blank) begin
          set_prog = 1'b1;
          set_done = 1'b1;
          st_d     = EN_IDLE;
        end else begin
          start_d = 1'b1;
          st_d    = EN_RUN;
        end
      end
      EN_RUN: begin
        if (fl_done) begin
          set_done = 1'b1;
          st_d     = EN_IDLE;
        end
      end
      default: st_d = EN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= EN_IDLE;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (cap_en) begin
      erase_q <= launch_erase;
      addr_q  <= tgt_addr;
      data_q  <= launch_data;
    end
  end

  assign busy     = (st_q != EN_IDLE);
  assign running  = (st_q == EN_RUN);
  assign fl_start = start_q;
  assign fl_erase = erase_q;
  assign fl_addr  = addr_q;
  assign fl_wdata = data_q;

endmodule

// File: rtl/flc_regs.sv
module flc_regs
  import flc_pkg::*;
#(
  parameter int FADDR_W = 16,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [RIDX_W-1:0]  reg_addr,
  input  logic [BUS_W-1:0]   reg_wdata,
  input  logic               busy,
  input  logic               main_open,
  input  logic               usd_open,
  input  logic               set_done,
  input  logic               set_prot,
  input  logic               set_prog,
  output logic [BUS_W-1:0]   reg_rdata,
  output logic               irq,
  output logic [FADDR_W-1:0] tgt_addr,
  output logic               launch,
  output logic               launch_erase,
  output logic [DATA_W-1:0]  launch_data,
  output logic [1:0]         key_wr,
  output logic [1:0]         relock,
  output logic [2:0]         flags
);

  logic sts_we, ctrl_we, addr_we;
  logic done_q, prot_q, prog_q;
  logic done_d, prot_d, prog_d;
  logic donie_q, errie_q;
  logic [FADDR_W-1:0] addr_q;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata;

  assign sts_we  = reg_wr && (reg_addr == RI_STS);
  assign ctrl_we = reg_wr && (reg_addr == RI_CTRL);
  assign addr_we = reg_wr && (reg_addr == RI_ADDR);

  assign key_wr[0] = reg_wr && (reg_addr == RI_KEY);
  assign key_wr[1] = reg_wr && (reg_addr == RI_UKEY);
  assign relock[0] = ctrl_we &&  reg_wdata[CT_LOCK];
  assign relock[1] = ctrl_we && !reg_wdata[CT_UOPEN];

  assign launch       = reg_wr && ((reg_addr == RI_PROG) || (reg_addr == RI_ERASE));
  assign launch_erase = (reg_addr == RI_ERASE);
  assign launch_data  = reg_wdata[DATA_W-1:0];

  // sticky flags: hardware set has priority over a write-one clear
  always_comb begin
    done_d = set_done | (done_q & ~(sts_we & reg_wdata[ST_DONE]));
    prot_d = set_prot | (prot_q & ~(sts_we & reg_wdata[ST_PROT]));
    prog_d = set_prog | (prog_q & ~(sts_we & reg_wdata[ST_PRG]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      prot_q <= 1'b0;
      prog_q <= 1'b0;
    end else begin
      done_q <= done_d;
      prot_q <= prot_d;
      prog_q <= prog_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      donie_q <= 1'b0;
      errie_q <= 1'b0;
    end else if (ctrl_we) begin
      donie_q <= reg_wdata[CT_DONIE];
      errie_q <= reg_wdata[CT_ERRIE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_we) addr_q <= reg_wdata[FADDR_W-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RI_STS: begin
        reg_rdata[ST_DONE] = done_q;
        reg_rdata[ST_PROT] = prot_q;
        reg_rdata[ST_PRG]  = prog_q;
        reg_rdata[ST_BUSY] = busy;
      end
      RI_CTRL: begin
        reg_rdata[CT_DONIE] = donie_q;
        reg_rdata[CT_ERRIE] = errie_q;
        reg_rdata[CT_UOPEN] = usd_open;
        reg_rdata[CT_LOCK]  = ~main_open;
      end
      RI_ADDR: reg_rdata = BUS_W'(addr_q);
      default: reg_rdata = '0;
    endcase
  end

  assign irq      = (done_q & donie_q) | ((prot_q | prog_q) & errie_q);
  assign tgt_addr = addr_q;
  assign flags    = {done_q, prot_q, prog_q};

endmodule

// File: rtl/flash_ctl_front.sv
module flash_ctl_front
  import flc_pkg::*;
#(
  parameter int          FADDR_W    = 16,
  parameter int          DATA_W     = 16,
  parameter int unsigned USD_BASE   = 32'h0000_F000,
  parameter int unsigned PROT_LO    = 32'h0000_0100,
  parameter int unsigned PROT_HI    = 32'h0000_01FF,
  parameter logic [31:0] KEY_FIRST  = 32'h4567_0123,
  parameter logic [31:0] KEY_SECOND = 32'hCDEF_89AB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               fl_start,
  output logic               fl_erase,
  output logic [FADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0]  fl_wdata,
  input  logic [DATA_W-1:0]  fl_cur,
  input  logic               fl_done,
  output logic               irq
);

  localparam int LANES = 2;   // 0: main array, 1: user data area

  logic rst_meta, rst_n_s;
  logic [LANES-1:0] key_wr, relock, open;
  logic main_open, usd_open;
  logic busy, running, launch, launch_erase;
  logic set_done, set_prot, set_prog;
  logic [FADDR_W-1:0] tgt_addr;
  logic [DATA_W-1:0]  launch_data;
  logic [2:0] flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  flc_regs #(.FADDR_W(FADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .busy(busy), .main_open(main_open), .usd_open(usd_open),
    .set_done(set_done), .set_prot(set_prot), .set_prog(set_prog),
    .reg_rdata(reg_rdata), .irq(irq), .tgt_addr(tgt_addr),
    .launch(launch), .launch_erase(launch_erase), .launch_data(launch_data),
    .key_wr(key_wr), .relock(relock), .flags(flags)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lock
    flc_unlock #(.KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_lock (
      .clk(clk), .rst_n(rst_n_s),
      .key_wr(key_wr[g]), .key_val(reg_wdata),
      .relock(relock[g]), .open(open[g])
    );
  end

  assign main_open = open[0];
  assign usd_open  = open[1];

  flc_engine #(
    .FADDR_W(FADDR_W), .DATA_W(DATA_W),
    .USD_BASE(USD_BASE), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)
  ) u_eng (
    .clk(clk), .rst_n(rst_n_s),
    .launch(launch), .launch_erase(launch_erase),
    .tgt_addr(tgt_addr), .launch_data(launch_data),
    .main_open(main_open), .usd_open(usd_open),
    .fl_cur(fl_cur), .fl_done(fl_done),
    .busy(busy), .running(running),
    .fl_start(fl_start), .fl_erase(fl_erase),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .set_done(set_done), .set_prot(set_prot), .set_prog(set_prog)
  );

endmodule

// File: rtl/flc_chk.sv
module flc_chk (
  input logic        clk,
  input logic        rst_n_s,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic        fl_start,
  input logic        fl_done,
  input logic        busy,
  input logic        running,
  input logic [2:0]  flags,
  input logic        irq,
  input logic        main_open,
  input logic        usd_open
);

  // R1
  key_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_addr == 3'd0 || reg_addr == 3'd1) |-> (reg_rdata == 32'd0));

  // R10
  sts_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_addr == 3'd2) |-> (reg_rdata[31:6] == 26'd0 && !reg_rdata[3] && !reg_rdata[1]));

  // R11
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    fl_start |=> !fl_start);

  // R11
  start_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    fl_start |-> busy);

  // R6
  done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (running && fl_done) |=> (flags[2] && !busy));

  // R2
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_wr && (reg_addr == 3'd5 || reg_addr == 3'd6) && !main_open && !usd_open && !busy)
      |=> !busy);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (flags == 3'b000) |-> !irq);

endmodule

bind flash_ctl_front flc_chk u_chk (
  .clk(clk), .rst_n_s(rst_n_s),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .fl_start(fl_start), .fl_done(fl_done),
  .busy(busy), .running(running), .flags(flags), .irq(irq),
  .main_open(main_open), .usd_open(usd_open)
);

// File: tb/tb_flash_ctl_front.sv
module tb_flash_ctl_front;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KA = 32'h4567_0123;
  localparam logic [31:0] KB = 32'hCDEF_89AB;
  localparam int NVEC = 7;
  // {erase, addr, data, cell value, expected status[5:0]}
  localparam logic [54:0] VECS [NVEC] = '{
    {1'b0, 16'h0010, 16'h1234, 16'hFFFF, 6'h20},
    {1'b0, 16'h0150, 16'h5555, 16'hFFFF, 6'h30},
    {1'b0, 16'h0020, 16'hABCD, 16'h00FF, 6'h24},
    {1'b1, 16'h0020, 16'h0000, 16'h0000, 6'h20},
    {1'b1, 16'h01FF, 16'h0000, 16'hFFFF, 6'h30},
    {1'b0, 16'h0200, 16'h0F0F, 16'hFFFF, 6'h20},
    {1'b0, 16'h00FF, 16'h7777, 16'hFFFE, 6'h24}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        fl_start, fl_erase;
  logic [15:0] fl_addr, fl_wdata, fl_cur;
  logic        fl_done;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int starts = 0;
  bit ended  = 1'b0;

  flash_ctl_front dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .fl_start(fl_start), .fl_erase(fl_erase),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_cur(fl_cur), .fl_done(fl_done), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (fl_start) starts++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    reg_addr = idx;
    #1 d = reg_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd7; reg_wdata = '0;
    fl_cur = 16'hFFFF; fl_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_op();
    repeat (2) @(negedge clk);
    fl_done = 1'b1;
    @(negedge clk);
    fl_done = 1'b0;
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    int s0;
    do_reset();

    // reset state
    rd(3'd2, v); chk("R5 reset status", v, 32'h0);
    rd(3'd3, v); chk("R2 reset control", v, 32'h80);
    chk("R9 reset irq", {31'd0, irq}, 32'd0);

    // launch while locked is dropped
    s0 = starts;
    wr(3'd4, 32'h10);
    wr(3'd5, 32'h1111);
    rd(3'd2, v); chk("R2 locked launch busy", v, 32'h0);
    @(negedge clk);
    rd(3'd2, v); chk("R2 locked launch status", v, 32'h0);
    chk("R2 locked launch no start", starts - s0, 0);

    // unlock main, key reads zero
    wr(3'd0, KA);
    rd(3'd0, v); chk("R1 key read", v, 32'h0);
    rd(3'd3, v); chk("R3 half key still locked", v, 32'h80);
    wr(3'd0, KB);
    rd(3'd0, v); chk("R1 key read after pair", v, 32'h0);
    rd(3'd1, v); chk("R1 user key read", v, 32'h0);
    rd(3'd3, v); chk("R3 unlocked", v, 32'h0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      logic        ver;
      logic [15:0] va, vd, vc;
      logic [5:0]  ve;
      bit          ok;
      {ver, va, vd, vc, ve} = VECS[i];
      ok = (ve == 6'h20);
      fl_cur = vc;
      s0 = starts;
      wr(3'd4, {16'h0, va});
      wr(ver ? 3'd6 : 3'd5, {16'h0, vd});
      rd(3'd2, v); chk("R5 busy after accept", v & 32'h1, 32'h1);
      @(negedge clk);
      if (ok) begin
        chk("R11 start pulse", {31'd0, fl_start}, 32'd1);
        chk("R11 start addr", {16'h0, fl_addr}, {16'h0, va});
        chk("R11 start op", {31'd0, fl_erase}, {31'd0, ver});
        if (!ver) chk("R11 start data", {16'h0, fl_wdata}, {16'h0, vd});
        rd(3'd2, v); chk("R5 busy while running", v & 32'h1, 32'h1);
        finish_op();
      end
      rd(3'd2, v);
      chk(ve == 6'h30 ? "R7 protection status" : (ve == 6'h24 ? "R8 not-erased status" : "R6 done status"),
          v, {26'd0, ve});
      chk("R11 start count", starts - s0, ok ? 1 : 0);
      wr(3'd2, 32'h34);
      rd(3'd2, v); chk("R6 write-one clear", v, 32'h0);
    end
    fl_cur = 16'hFFFF;

    // launch while busy is dropped
    s0 = starts;
    wr(3'd4, 32'h30);
    wr(3'd5, 32'hAAAA);
    wr(3'd5, 32'hBBBB);
    chk("R5 second launch ignored data", {16'h0, fl_wdata}, 32'hAAAA);
    finish_op();
    @(negedge clk);
    chk("R5 one start while busy", starts - s0, 1);
    rd(3'd2, v); chk("R6 done after busy test", v, 32'h20);

    // interrupt combination; done flag set now
    chk("R9 irq no enables", {31'd0, irq}, 32'd0);
    wr(3'd2, 32'h0);
    rd(3'd2, v); chk("R6 write zero keeps done", v, 32'h20);
    wr(3'd3, 32'h400);
    chk("R9 errie with only done", {31'd0, irq}, 32'd0);
    wr(3'd3, 32'h1000);
    chk("R9 done enable", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'h20);
    chk("R9 done cleared", {31'd0, irq}, 32'd0);
    wr(3'd4, 32'h180);
    wr(3'd5, 32'h1);
    @(negedge clk);
    rd(3'd2, v); chk("R7 protection busy low", v, 32'h30);
    wr(3'd3, 32'h400);
    chk("R9 error enable", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'h20);
    chk("R9 error term alone", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'hFFFF_FFCB);
    rd(3'd2, v); chk("R10 reserved write ignored", v, 32'h10);
    wr(3'd3, 32'h1000);
    chk("R9 error masked", {31'd0, irq}, 32'd0);
    wr(3'd2, 32'h10);

    // user area
    s0 = starts;
    wr(3'd4, 32'hF010);
    wr(3'd5, 32'h2222);
    @(negedge clk);
    rd(3'd2, v); chk("R4 user area locked", v, 32'h0);
    wr(3'd1, KA);
    wr(3'd1, KB);
    rd(3'd3, v); chk("R4 user open bit", v, 32'h1200);
    wr(3'd5, 32'h2222);
    @(negedge clk);
    chk("R4 user start", {31'd0, fl_start}, 32'd1);
    finish_op();
    rd(3'd2, v); chk("R4 user done", v, 32'h20);
    wr(3'd2, 32'h20);
    wr(3'd3, 32'h0);
    rd(3'd3, v); chk("R4 user relock", v, 32'h0);
    wr(3'd5, 32'h3333);
    @(negedge clk);
    chk("R4 relocked no start", starts - s0, 1);

    // relock main, re-open, then jam
    wr(3'd3, 32'h80);
    rd(3'd3, v); chk("R3 relock", v, 32'h80);
    wr(3'd4, 32'h40);
    wr(3'd5, 32'h1);
    @(negedge clk);
    rd(3'd2, v); chk("R3 relocked launch dropped", v, 32'h0);
    wr(3'd0, KA); wr(3'd0, KB);
    rd(3'd3, v); chk("R3 re-open", v, 32'h0);
    wr(3'd3, 32'h80);
    wr(3'd0, KB);
    wr(3'd0, KA); wr(3'd0, KB);
    rd(3'd3, v); chk("R3 jammed", v, 32'h80);

    do_reset();
    wr(3'd0, KA); wr(3'd0, KB);
    rd(3'd3, v); chk("R3 reset clears jam", v, 32'h0);

    summary();
  end

endmodule